// File: doc/BRIEF.md
# Physical Register Ready Scoreboard

This block keeps one ready bit for every physical register in an out-of-order core. Integer and floating-point physical registers share a single flat index range. Integer register `i` maps to flat index `i`. Floating-point register `j` maps to flat index `NUM_INT + j`. Callers name a register by a class flag and a class-local index, and the block performs the mapping.

Each cycle the block can accept three kinds of input:

- up to two producer registrations, which mark a register as awaiting its value;
- up to two completions, which mark a register as holding its value;
- up to three source-readiness queries from an instruction entering the window.

A registration does not require the instruction to enter the issue window. Queries see the effect of the same cycle's events through a bypass path. The block also broadcasts the flat index of every register that a completion woke, one cycle later. That broadcast wakes the consumers held elsewhere.

Top module: `phys_reg_scoreboard`

## Requirements
- R1: After reset, every physical register reads as ready.
- R2: Integer local index `i` maps to flat index `i`, and floating-point local index `j` maps to flat index `NUM_INT + j`. With the defaults, integer registers occupy flat 0..95 and floating-point registers occupy flat 96..191. The mapped flat index appears on the broadcast output.
- R3: An event or query whose local index is at or beyond its class size is ignored. It changes no bit, produces no broadcast, and a query with such an index returns 0.
- R4: A producer registration clears the register's ready bit. From the next cycle onward, queries return 0 until a completion arrives.
- R5: A completion sets the register's ready bit. From the next cycle onward, queries return 1 until a new registration arrives.
- R6: Two completions and two registrations in one cycle all take effect, each on its own register.
- R7: If a registration and a completion name the same register in one cycle, the registration wins and the bit ends up 0.
- R8: A query returns the register's state with the same cycle's events already applied. A same-cycle completion reads 1, and a same-cycle registration reads 0, with R7 resolving a collision.
- R9: One cycle after a valid, in-range completion on port `w`, `bcast_vld[w]` is 1 and `bcast_reg` slice `w` (FLAT_W bits at bit `w*FLAT_W`) holds its flat index. The broadcast happens even when R7 keeps the bit at 0. Without such a completion, `bcast_vld[w]` is 0.
- R10: A query slot whose valid bit is 0 returns 0.
- R11: Without valid events, every ready bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wake_vld | input | NUM_WAKE | Completion valid, one per port |
| wake_fp | input | NUM_WAKE | Completion register class, 1 = floating point |
| wake_idx | input | NUM_WAKE*LOC_W | Completion class-local index, slice per port |
| prod_vld | input | NUM_PROD | Producer registration valid |
| prod_fp | input | NUM_PROD | Registration register class, 1 = floating point |
| prod_idx | input | NUM_PROD*LOC_W | Registration class-local index |
| src_vld | input | NUM_SRC | Source query valid |
| src_fp | input | NUM_SRC | Source register class, 1 = floating point |
| src_idx | input | NUM_SRC*LOC_W | Source class-local index |
| src_rdy | output | NUM_SRC | Source ready, combinational with bypass |
| bcast_vld | output | NUM_WAKE | Woken-register broadcast valid, registered |
| bcast_reg | output | NUM_WAKE*FLAT_W | Woken flat index, slice per port |

## Verification
The results become due at different times:

- `src_rdy` depends only on the inputs and the stored bits, so it is due in the same cycle as the query. The bench drives all inputs just after a falling edge and samples `src_rdy` 1 ns later, well before the next rising edge.
- The broadcast goes through one register. The bench records each cycle's in-range completions and compares them against `bcast_vld` and `bcast_reg` at the following sample point.
- Effects on stored state are due one edge later. The bench's reference array is advanced once per cycle, after that cycle's checks and before the rising edge. This keeps queries in later cycles aligned with what the design holds.

// File: rtl/prs_pkg.sv
`timescale 1ns/1ps
package prs_pkg;

  typedef enum logic {
    RCLS_INT = 1'b0,
    RCLS_FP  = 1'b1
  } reg_class_e;

  function automatic int unsigned class_size(input reg_class_e cls,
                                             input int unsigned n_int,
                                             input int unsigned n_fp);
    return (cls == RCLS_FP) ? n_fp : n_int;
  endfunction

endpackage

// File: rtl/sb_rst_sync.sv
`timescale 1ns/1ps
module sb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sb_index_map.sv
`timescale 1ns/1ps
module sb_index_map
  import prs_pkg::*;
#(
  parameter int NUM_INT = 96,
  parameter int NUM_FP  = 96,
  parameter int LOC_W   = 7,
  parameter int FLAT_W  = 8,
  parameter int N       = 2
) (
  input  logic [N-1:0]             in_vld,
  input  logic [N-1:0]             in_fp,
  input  logic [N*LOC_W-1:0]       in_loc,
  output logic [N-1:0]             out_ok,
  output logic [N-1:0][FLAT_W-1:0] out_flat
);

  for (genvar i = 0; i < N; i++) begin : g_map
    reg_class_e         cls;
    logic [LOC_W-1:0]   loc;
    logic               in_range;

    assign cls      = reg_class_e'(in_fp[i]);
    assign loc      = in_loc[i*LOC_W +: LOC_W];
    assign in_range = (32'(loc) < class_size(cls, NUM_INT, NUM_FP));

    always_comb begin
      out_ok[i] = in_vld[i] & in_range;
      if (cls == RCLS_FP) begin
        out_flat[i] = FLAT_W'(NUM_INT) + FLAT_W'(loc);
      end else begin
        out_flat[i] = FLAT_W'(loc);
      end
    end

    always_comb begin
      if (out_ok[i] && cls == RCLS_FP) begin
        AST_FP_ABOVE_INT: assert (32'(out_flat[i]) >= NUM_INT); // R2
      end
      if (out_ok[i]) begin
        AST_FLAT_IN_SPACE: assert (32'(out_flat[i]) < NUM_INT + NUM_FP); // R3
      end
    end
  end

endmodule

// File: rtl/sb_ready_array.sv
`timescale 1ns/1ps
module sb_ready_array #(
  parameter int NUM_REGS = 192,
  parameter int FLAT_W   = 8,
  parameter int NW       = 2,
  parameter int NP       = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NW-1:0]             set_ok,
  input  logic [NW-1:0][FLAT_W-1:0] set_flat,
  input  logic [NP-1:0]             clr_ok,
  input  logic [NP-1:0][FLAT_W-1:0] clr_flat,
  output logic [NUM_REGS-1:0]       rdy_q,
  output logic [NUM_REGS-1:0]       rdy_nxt
);

  logic upd_en;

  assign upd_en = (|set_ok) | (|clr_ok);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [NW-1:0] s_m;
    logic [NP-1:0] c_m;
    for (genvar w = 0; w < NW; w++) begin : g_s
      assign s_m[w] = set_ok[w] & (set_flat[w] == FLAT_W'(r));
    end
    for (genvar p = 0; p < NP; p++) begin : g_c
      assign c_m[p] = clr_ok[p] & (clr_flat[p] == FLAT_W'(r));
    end
    // a new producer overrides a completion on the same register
    assign rdy_nxt[r] = ~(|c_m) & ((|s_m) | rdy_q[r]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '1;
    end else if (upd_en) begin
      rdy_q <= rdy_nxt;
    end
  end

  // checker support: remember last cycle's events
  logic [NP-1:0]             chk_clr_ok;
  logic [NP-1:0][FLAT_W-1:0] chk_clr_flat;
  logic [NW-1:0]             chk_set_win;
  logic [NW-1:0][FLAT_W-1:0] chk_set_flat;
  logic [NW-1:0]             set_win_d;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      set_win_d[w] = set_ok[w];
      for (int p = 0; p < NP; p++) begin
        if (clr_ok[p] && clr_flat[p] == set_flat[w]) begin
          set_win_d[w] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_clr_ok   <= '0;
      chk_clr_flat <= '0;
      chk_set_win  <= '0;
      chk_set_flat <= '0;
    end else begin
      chk_clr_ok   <= clr_ok;
      chk_clr_flat <= clr_flat;
      chk_set_win  <= set_win_d;
      chk_set_flat <= set_flat;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_ast_c
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      chk_clr_ok[p] |-> !rdy_q[chk_clr_flat[p]]); // R7
  end

  for (genvar w = 0; w < NW; w++) begin : g_ast_s
    AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      chk_set_win[w] |-> rdy_q[chk_set_flat[w]]); // R5
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_ok) && !(|clr_ok)) |=> $stable(rdy_q)); // R11

endmodule

// File: rtl/sb_wake_bcast.sv
`timescale 1ns/1ps
module sb_wake_bcast #(
  parameter int NW     = 2,
  parameter int FLAT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NW-1:0]             wk_ok,
  input  logic [NW-1:0][FLAT_W-1:0] wk_flat,
  output logic [NW-1:0]             bc_vld,
  output logic [NW*FLAT_W-1:0]      bc_reg
);

  logic [NW-1:0]        vld_d;
  logic [NW*FLAT_W-1:0] reg_d;

  always_comb begin
    vld_d = wk_ok;
    for (int w = 0; w < NW; w++) begin
      reg_d[w*FLAT_W +: FLAT_W] = wk_ok[w] ? wk_flat[w] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_vld <= '0;
      bc_reg <= '0;
    end else begin
      bc_vld <= vld_d;
      bc_reg <= reg_d;
    end
  end

endmodule

// File: rtl/phys_reg_scoreboard.sv
`timescale 1ns/1ps
module phys_reg_scoreboard #(
  parameter int NUM_INT  = 96,
  parameter int NUM_FP   = 96,
  parameter int NUM_WAKE = 2,
  parameter int NUM_PROD = 2,
  parameter int NUM_SRC  = 3,
  parameter int LOC_W    = $clog2((NUM_INT > NUM_FP) ? NUM_INT : NUM_FP),
  parameter int FLAT_W   = $clog2(NUM_INT + NUM_FP)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_WAKE-1:0]        wake_vld,
  input  logic [NUM_WAKE-1:0]        wake_fp,
  input  logic [NUM_WAKE*LOC_W-1:0]  wake_idx,
  input  logic [NUM_PROD-1:0]        prod_vld,
  input  logic [NUM_PROD-1:0]        prod_fp,
  input  logic [NUM_PROD*LOC_W-1:0]  prod_idx,
  input  logic [NUM_SRC-1:0]         src_vld,
  input  logic [NUM_SRC-1:0]         src_fp,
  input  logic [NUM_SRC*LOC_W-1:0]   src_idx,
  output logic [NUM_SRC-1:0]         src_rdy,
  output logic [NUM_WAKE-1:0]        bcast_vld,
  output logic [NUM_WAKE*FLAT_W-1:0] bcast_reg
);

  localparam int NUM_REGS = NUM_INT + NUM_FP;

  logic                             rst_int_n;
  logic [NUM_WAKE-1:0]              wk_ok;
  logic [NUM_WAKE-1:0][FLAT_W-1:0]  wk_flat;
  logic [NUM_PROD-1:0]              pr_ok;
  logic [NUM_PROD-1:0][FLAT_W-1:0]  pr_flat;
  logic [NUM_SRC-1:0]               sq_ok;
  logic [NUM_SRC-1:0][FLAT_W-1:0]   sq_flat;
  logic [NUM_REGS-1:0]              rdy_q;
  logic [NUM_REGS-1:0]              rdy_nxt;

  sb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sb_index_map #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .LOC_W(LOC_W),
                 .FLAT_W(FLAT_W), .N(NUM_WAKE)) u_map_wake (
    .in_vld (wake_vld), .in_fp (wake_fp), .in_loc (wake_idx),
    .out_ok (wk_ok),    .out_flat (wk_flat)
  );

  sb_index_map #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .LOC_W(LOC_W),
                 .FLAT_W(FLAT_W), .N(NUM_PROD)) u_map_prod (
    .in_vld (prod_vld), .in_fp (prod_fp), .in_loc (prod_idx),
    .out_ok (pr_ok),    .out_flat (pr_flat)
  );

  sb_index_map #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .LOC_W(LOC_W),
                 .FLAT_W(FLAT_W), .N(NUM_SRC)) u_map_src (
    .in_vld (src_vld), .in_fp (src_fp), .in_loc (src_idx),
    .out_ok (sq_ok),   .out_flat (sq_flat)
  );

  sb_ready_array #(.NUM_REGS(NUM_REGS), .FLAT_W(FLAT_W),
                   .NW(NUM_WAKE), .NP(NUM_PROD)) u_array (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_ok   (wk_ok),
    .set_flat (wk_flat),
    .clr_ok   (pr_ok),
    .clr_flat (pr_flat),
    .rdy_q    (rdy_q),
    .rdy_nxt  (rdy_nxt)
  );

  sb_wake_bcast #(.NW(NUM_WAKE), .FLAT_W(FLAT_W)) u_bcast (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wk_ok   (wk_ok),
    .wk_flat (wk_flat),
    .bc_vld  (bcast_vld),
    .bc_reg  (bcast_reg)
  );

  // queries read the post-event value: same-cycle bypass
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_query
    assign src_rdy[s] = sq_ok[s] & rdy_nxt[sq_flat[s]];
  end

  // checker support for the query assertions
  logic [NUM_SRC-1:0] chk_src_wk;
  logic [NUM_SRC-1:0] chk_src_pr;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      chk_src_wk[s] = 1'b0;
      chk_src_pr[s] = 1'b0;
      for (int w = 0; w < NUM_WAKE; w++) begin
        if (wk_ok[w] && wk_flat[w] == sq_flat[s]) chk_src_wk[s] = 1'b1;
      end
      for (int p = 0; p < NUM_PROD; p++) begin
        if (pr_ok[p] && pr_flat[p] == sq_flat[s]) chk_src_pr[s] = 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_ast_q
    AST_QUERY_BYPASS_SET: assert property (@(posedge clk) disable iff (!rst_int_n)
      (sq_ok[s] && chk_src_wk[s] && !chk_src_pr[s]) |-> src_rdy[s]); // R8
    AST_QUERY_BYPASS_CLR: assert property (@(posedge clk) disable iff (!rst_int_n)
      (sq_ok[s] && chk_src_pr[s]) |-> !src_rdy[s]); // R8
    AST_QUERY_INVALID: assert property (@(posedge clk) disable iff (!rst_int_n)
      !src_vld[s] |-> !src_rdy[s]); // R10
  end

  for (genvar w = 0; w < NUM_WAKE; w++) begin : g_ast_b
    AST_BCAST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_int_n)
      wk_ok[w] |=> (bcast_vld[w] &&
                    bcast_reg[w*FLAT_W +: FLAT_W] == $past(wk_flat[w]))); // R9
    AST_BCAST_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
      !wake_vld[w] |=> !bcast_vld[w]); // R9
  end

endmodule

// File: tb/tb_phys_reg_scoreboard.sv
`timescale 1ns/1ps
module tb_phys_reg_scoreboard;

  localparam int NI = 96;
  localparam int NF = 96;
  localparam int NR = NI + NF;
  localparam int NW = 2;
  localparam int NP = 2;
  localparam int NS = 3;
  localparam int LW = 7;
  localparam int FW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NW-1:0]   wake_vld, wake_fp;
  logic [NW*LW-1:0] wake_idx;
  logic [NP-1:0]   prod_vld, prod_fp;
  logic [NP*LW-1:0] prod_idx;
  logic [NS-1:0]   src_vld, src_fp;
  logic [NS*LW-1:0] src_idx;
  logic [NS-1:0]   src_rdy;
  logic [NW-1:0]   bcast_vld;
  logic [NW*FW-1:0] bcast_reg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit mdl [NR];
  bit pv  [NW];
  int pf  [NW];

  always #2.5 clk = ~clk;

  phys_reg_scoreboard dut (
    .clk(clk), .rst_n(rst_n),
    .wake_vld(wake_vld), .wake_fp(wake_fp), .wake_idx(wake_idx),
    .prod_vld(prod_vld), .prod_fp(prod_fp), .prod_idx(prod_idx),
    .src_vld(src_vld), .src_fp(src_fp), .src_idx(src_idx),
    .src_rdy(src_rdy), .bcast_vld(bcast_vld), .bcast_reg(bcast_reg)
  );

  function automatic int fl(input bit fp, input int idx);
    return fp ? NI + idx : idx;
  endfunction

  function automatic bit okf(input bit v, input bit fp, input int idx);
    return v && (idx < (fp ? NF : NI));
  endfunction

  function automatic bit nxt_bit(input int r);
    bit s = 1'b0;
    bit c = 1'b0;
    for (int w = 0; w < NW; w++) begin
      int ix = int'(wake_idx[w*LW +: LW]);
      if (okf(wake_vld[w], wake_fp[w], ix) && fl(wake_fp[w], ix) == r) s = 1'b1;
    end
    for (int p = 0; p < NP; p++) begin
      int ix = int'(prod_idx[p*LW +: LW]);
      if (okf(prod_vld[p], prod_fp[p], ix) && fl(prod_fp[p], ix) == r) c = 1'b1;
    end
    if (c) return 1'b0;
    if (s) return 1'b1;
    return mdl[r];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    wake_vld = '0; wake_fp = '0; wake_idx = '0;
    prod_vld = '0; prod_fp = '0; prod_idx = '0;
    src_vld  = '0; src_fp  = '0; src_idx  = '0;
  endtask

  task automatic wk(input int w, input bit fp, input int idx);
    wake_vld[w] = 1'b1; wake_fp[w] = fp; wake_idx[w*LW +: LW] = LW'(idx);
  endtask

  task automatic pr(input int p, input bit fp, input int idx);
    prod_vld[p] = 1'b1; prod_fp[p] = fp; prod_idx[p*LW +: LW] = LW'(idx);
  endtask

  task automatic sq(input int s, input bit fp, input int idx);
    src_vld[s] = 1'b1; src_fp[s] = fp; src_idx[s*LW +: LW] = LW'(idx);
  endtask

  // called just after a falling edge with inputs applied
  task automatic tick(input string qtag);
    bit tmp [NR];
    #1;
    for (int s = 0; s < NS; s++) begin
      int ix = int'(src_idx[s*LW +: LW]);
      bit e = okf(src_vld[s], src_fp[s], ix) ? nxt_bit(fl(src_fp[s], ix)) : 1'b0;
      chk(qtag, int'(src_rdy[s]), int'(e));
    end
    for (int w = 0; w < NW; w++) begin
      chk("R9", int'(bcast_vld[w]), int'(pv[w]));
      if (pv[w]) chk("R2", int'(bcast_reg[w*FW +: FW]), pf[w]);
    end
    for (int r = 0; r < NR; r++) tmp[r] = nxt_bit(r);
    for (int r = 0; r < NR; r++) mdl[r] = tmp[r];
    for (int w = 0; w < NW; w++) begin
      int ix = int'(wake_idx[w*LW +: LW]);
      pv[w] = okf(wake_vld[w], wake_fp[w], ix);
      pf[w] = fl(wake_fp[w], ix);
    end
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < NR; r++) mdl[r] = 1'b1;
    for (int w = 0; w < NW; w++) begin pv[w] = 1'b0; pf[w] = 0; end
    rst_n = 1'b0;
    idle();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, corners of both classes
    sq(0, 1'b0, 0); sq(1, 1'b1, 95); sq(2, 1'b0, 95);
    tick("R1");

    // R4 via R8: registration visible in the same cycle
    pr(0, 1'b0, 5); pr(1, 1'b1, 3);
    sq(0, 1'b0, 5); sq(1, 1'b1, 3); sq(2, 1'b0, 6);
    tick("R8");
    sq(0, 1'b0, 5); sq(1, 1'b1, 3); sq(2, 1'b0, 6);
    tick("R4");

    // R5: completion bypassed then stored
    wk(1, 1'b0, 5);
    sq(0, 1'b0, 5); sq(1, 1'b1, 3);
    tick("R8");
    sq(0, 1'b0, 5); sq(1, 1'b1, 3);
    tick("R5");
    sq(0, 1'b0, 5); sq(1, 1'b1, 3);
    tick("R11");

    // R7: collision on int 7, clear wins, broadcast still issued
    wk(0, 1'b0, 7); pr(1, 1'b0, 7);
    sq(0, 1'b0, 7);
    tick("R7");
    sq(0, 1'b0, 7);
    tick("R7");

    // R6: two completions and two registrations together
    wk(0, 1'b0, 7); wk(1, 1'b1, 3); pr(0, 1'b0, 10); pr(1, 1'b1, 90);
    tick("R6");
    sq(0, 1'b0, 7); sq(1, 1'b1, 3); sq(2, 1'b0, 10);
    tick("R6");
    sq(0, 1'b1, 90);
    tick("R6");

    // R3: int local 100 would alias fp 4 (flat 100) if not rejected
    pr(0, 1'b1, 4);
    tick("R4");
    wk(0, 1'b0, 100); pr(1, 1'b1, 100);
    sq(0, 1'b1, 4); sq(1, 1'b0, 100); sq(2, 1'b1, 127);
    tick("R3");
    sq(0, 1'b1, 4);
    tick("R3");

    // R10: invalid slot with a ready register behind it
    src_fp[0] = 1'b0; src_idx[0 +: LW] = LW'(5);
    tick("R10");

    // R2: top of the fp range broadcast
    wk(1, 1'b1, 95);
    tick("R2");
    tick("R2");

    // mixed random traffic
    for (int c = 0; c < 3000; c++) begin
      for (int w = 0; w < NW; w++)
        if ($urandom % 2 == 0)
          wk(w, 1'($urandom % 2), ($urandom % 5 == 0) ? int'($urandom % 128) : int'($urandom % 6));
      for (int p = 0; p < NP; p++)
        if ($urandom % 2 == 0)
          pr(p, 1'($urandom % 2), ($urandom % 5 == 0) ? int'($urandom % 128) : int'($urandom % 6));
      for (int s = 0; s < NS; s++) begin
        src_vld[s] = 1'($urandom % 4 != 0);
        src_fp[s]  = 1'($urandom % 2);
        src_idx[s*LW +: LW] = LW'(($urandom % 6 == 0) ? $urandom % 128 : $urandom % 6);
      end
      tick("R8");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule